// File: doc/BRIEF.md
# Bidirectional Port with Upper-Nibble Change Interrupt

This block is an eight-pin general-purpose port. Each pin has its own direction bit and a shared output data latch, and it can enable a weak pull-up. A small register bus writes and reads the port, the direction register, an option register and an interrupt control register. Pin levels reach the logic through a two-flop synchronizer. The read path and the change detector both use these synchronized levels.

The upper four pins can raise one shared change interrupt. A compare latch holds the upper pin levels as they stood at the last port access, meaning a read or a write of the port. Each upper pin that is an input is compared with its latch bit. The compare results are ORed into a mismatch signal. A small state machine holds the resulting sticky flag. It has two states, FLAG_IDLE and FLAG_RAISED. The transition FLAG_IDLE to FLAG_RAISED happens on any mismatch. The transition FLAG_RAISED to FLAG_IDLE happens on a software clear, but only when no mismatch is present. A mismatch therefore keeps setting the flag until software accesses the port, which reloads the latch. The flag also drives a wake-up request, so a sleeping system resumes on a key press.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset, all pins are inputs (direction register 8'hFF, `pin_oe` 0), the output latch is 0, the option register reads 8'h80 (pull-ups disabled), `pin_pu` is 0 and the change flag is 0.
- R2: Register addresses are 0 = port, 1 = direction, 2 = option, 3 = interrupt control. A port write updates only the output latch. `pin_out` always shows that latch. `pin_oe[i]` is 1 exactly when direction bit i is 0 (output).
- R3: A port read returns the synchronized pin level for each input bit and the output latch bit for each output bit. A pin change is visible on a read after two clock edges.
- R4: Only bits 7 to 4 take part in change detection, and only while their direction bit is 1. A change on bits 3 to 0, or on an upper bit set as output, never sets the flag.
- R5: A mismatch sets the flag on the next clock edge. Writing interrupt control with bit 0 = 0 clears the flag. When a mismatch is present in the same cycle, the set wins and the flag stays 1.
- R6: Any port read or port write loads the compare latch with the synchronized upper pin levels. This ends the mismatch, and a later clear then takes effect.
- R7: `pin_pu[i]` is 1 exactly when direction bit i is 1 and option bit 7 is 0.
- R8: `wake_req` and `irq_flag` both equal the flag, and interrupt control bit 0 reads back the flag.
- R9: Writing interrupt control with bit 0 = 1 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a port read re-arms detection) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Output latch value to pins |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| irq_flag | output | 1 | Sticky port-change flag |
| wake_req | output | 1 | Wake-up request from sleep |

## Verification
The bench drives a pin change at a falling edge. It expects the synchronized level to be readable after two rising edges and the flag one rising edge after that. It checks that the flag is still 0 at the second edge and is 1 at the third. Register writes, re-arming and clears take effect on the rising edge inside the access, so each of their results is sampled at the following falling edge. Direction, output enable and pull-up results are combinational from the registers and are checked one falling edge after the write.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

    typedef enum logic [1:0] {
        REG_PORT = 2'd0,
        REG_DIR  = 2'd1,
        REG_OPT  = 2'd2,
        REG_IRQ  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
    parameter int W      = 8,
    parameter int CHG_LO = 4,
    localparam int CHG_W = W - CHG_LO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rearm,
    input  logic [CHG_W-1:0] lvl,
    input  logic [CHG_W-1:0] is_in,
    output logic [CHG_W-1:0] cmp_q,
    output logic             chg_any
);
    logic [CHG_W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cmp_q <= '0;
        else if (rearm) cmp_q <= lvl;
    end

    for (genvar b = 0; b < CHG_W; b++) begin : g_cmp
        assign diff[b] = is_in[b] & (lvl[b] ^ cmp_q[b]);
    end

    assign chg_any = |diff;
endmodule

// File: rtl/gpio_chg_flag.sv
module gpio_chg_flag
    import gpio_chg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (set_req) state_d = FLAG_RAISED;
            FLAG_RAISED: if (clr_req && !set_req) state_d = FLAG_IDLE;
            default:     state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_RAISED);
    end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
    import gpio_chg_pkg::*;
#(
    parameter int W           = 8,
    parameter int CHG_LO      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int PU_BIT      = 7,
    localparam int CHG_W      = W - CHG_LO
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   addr,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pu,
    output logic         irq_flag,
    output logic         wake_req
);
    logic [W-1:0]     out_q, dir_q, opt_q, sync_q;
    logic [CHG_W-1:0] cmp_q;
    logic             chg_any, port_acc, clr_req;
    reg_sel_e         sel;

    assign sel      = reg_sel_e'(addr);
    assign port_acc = (wr_en || rd_en) && (sel == REG_PORT);
    assign clr_req  = wr_en && (sel == REG_IRQ) && !wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '1;
            opt_q <= W'(1) << PU_BIT;
        end else if (wr_en) begin
            unique case (sel)
                REG_PORT: out_q <= wdata;
                REG_DIR:  dir_q <= wdata;
                REG_OPT:  opt_q <= wdata;
                REG_IRQ:  ;
                default:  ;
            endcase
        end
    end

    gpio_chg_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
    );

    gpio_chg_detect #(.W(W), .CHG_LO(CHG_LO)) u_det (
        .clk(clk), .rst_n(rst_n), .rearm(port_acc),
        .lvl(sync_q[W-1:CHG_LO]), .is_in(dir_q[W-1:CHG_LO]),
        .cmp_q(cmp_q), .chg_any(chg_any)
    );

    gpio_chg_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_req(chg_any),
        .clr_req(clr_req), .flag(irq_flag)
    );

    always_comb begin
        unique case (sel)
            REG_PORT: rdata = (sync_q & dir_q) | (out_q & ~dir_q);
            REG_DIR:  rdata = dir_q;
            REG_OPT:  rdata = opt_q;
            REG_IRQ:  rdata = {{(W-1){1'b0}}, irq_flag};
            default:  rdata = '0;
        endcase
    end

    assign pin_out  = out_q;
    assign pin_oe   = ~dir_q;
    assign pin_pu   = opt_q[PU_BIT] ? '0 : dir_q;
    assign wake_req = irq_flag;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
    parameter int W      = 8,
    parameter int CHG_LO = 4,
    localparam int CHG_W = W - CHG_LO
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_acc,
    input logic             clr_req,
    input logic [W-1:0]     sync_q,
    input logic [CHG_W-1:0] cmp_q,
    input logic             chg_any,
    input logic             irq_flag,
    input logic [W-1:0]     pin_oe,
    input logic [W-1:0]     pin_pu
);
    AST_SET_NEXT: assert property (@(posedge clk) disable iff (!rst_n) chg_any |=> irq_flag); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq_flag && !clr_req) |=> irq_flag); // R5
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (irq_flag && clr_req && !chg_any) |=> !irq_flag); // R5
    AST_ONLY_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_flag) |-> $past(chg_any)); // R4
    AST_REARM: assert property (@(posedge clk) disable iff (!rst_n) port_acc |=> (cmp_q == $past(sync_q[W-1:CHG_LO]))); // R6
    AST_PU_NOT_OUT: assert property (@(posedge clk) disable iff (!rst_n) (pin_pu & pin_oe) == '0); // R7
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(W), .CHG_LO(CHG_LO)) u_chk (
    .clk(clk), .rst_n(rst_n), .port_acc(port_acc), .clr_req(clr_req),
    .sync_q(sync_q), .cmp_q(cmp_q), .chg_any(chg_any), .irq_flag(irq_flag),
    .pin_oe(pin_oe), .pin_pu(pin_pu)
);

// File: tb/tb_gpio_chg_port.sv
module tb_gpio_chg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'd0, rdata, pin_in = 8'd0;
    logic [7:0] pin_out, pin_oe, pin_pu;
    logic       irq_flag, wake_req;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_chg_port dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu), .irq_flag(irq_flag), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected<=150000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 pin_pu", pin_pu, 8'h00);
        chk("R1 flag", {7'd0, irq_flag}, 8'h00);
        rd(2'd1, v); chk("R1 dir", v, 8'hFF);
        rd(2'd2, v); chk("R1 opt", v, 8'h80);

        // R2 R7 sweep of direction with both pull-up settings
        for (int o = 0; o < 2; o++) begin
            wr(2'd2, o ? 8'h80 : 8'h00);
            for (int d = 0; d < 256; d++) begin
                wr(2'd1, 8'(d));
                chk("R2 pin_oe", pin_oe, ~8'(d));
                chk("R7 pin_pu", pin_pu, o ? 8'h00 : 8'(d));
            end
        end
        wr(2'd2, 8'h80);

        // R2 R3 read mux over direction patterns
        for (int d = 0; d < 256; d += 3) begin
            logic [7:0] dv, ov, pv;
            dv = 8'(d); ov = dv ^ 8'h5A; pv = 8'(d * 7 + 3);
            wr(2'd1, dv);
            wr(2'd0, ov);
            chk("R2 pin_out", pin_out, ov);
            rd(2'd1, v); chk("R2 dir kept", v, dv);
            pin_in = pv;
            tick(2);
            rd(2'd0, v);
            chk("R3 read mux", v, (pv & dv) | (ov & ~dv));
        end
        pin_in = 8'h00;

        // R4 R5 R6 R8 single-pin change sweep
        for (int d = 0; d < 16; d++) begin
            for (int b = 0; b < 8; b++) begin
                logic [7:0] dv;
                logic exp;
                dv = {4'(d), ~4'(d)};
                exp = (b >= 4) && dv[b];
                wr(2'd1, dv);
                pin_in = 8'h00;
                tick(3);
                rd(2'd0, v);
                wr(2'd3, 8'h00);
                chk("R5 clear armed", {7'd0, irq_flag}, 8'h00);
                pin_in = 8'h01 << b;
                tick(2);
                chk("R5 not yet", {7'd0, irq_flag}, 8'h00);
                tick(1);
                chk("R4 flag on change", {7'd0, irq_flag}, {7'd0, exp});
                chk("R8 wake", {7'd0, wake_req}, {7'd0, exp});
                if (exp) begin
                    rd(2'd3, v);
                    chk("R8 ctrl read", v, 8'h01);
                    wr(2'd3, 8'h00);
                    chk("R5 set wins", {7'd0, irq_flag}, 8'h01);
                    if (b[0]) rd(2'd0, v);
                    else      wr(2'd0, 8'h00);
                    wr(2'd3, 8'h00);
                    chk("R6 rearm then clear", {7'd0, irq_flag}, 8'h00);
                end
            end
        end

        // R9 writing bit0=1 keeps the flag
        wr(2'd1, 8'hF0);
        pin_in = 8'h00;
        tick(3);
        rd(2'd0, v);
        wr(2'd3, 8'h00);
        wr(2'd3, 8'h01);
        chk("R9 flag stays 0", {7'd0, irq_flag}, 8'h00);
        pin_in = 8'h80;
        tick(3);
        rd(2'd0, v);
        wr(2'd3, 8'h01);
        chk("R9 flag stays 1", {7'd0, irq_flag}, 8'h01);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule